// File: doc/BRIEF.md
# Four-Channel Pulse-Width Modulator with Boundary-Staged Updates

This block drives four independent pulse-width modulated outputs from one clock. Each channel owns a counter that runs from zero up to its period length minus one, advancing on a tick taken from a power-of-two prescaler. A period opens at the inactive level and the output turns active once the count reaches the channel's threshold value. The active share of a period is therefore the period length minus the threshold. A polarity bit per channel flips the sense of the pin.

Software drives the block through a small memory-mapped port: a write strobe, a read strobe, a 12-bit byte address and 32-bit data. Read data is combinational and valid in the same cycle as the read strobe. Setup registers can only be changed while a channel is stopped. A running channel can still be retuned through a staging register whose value lands at the next period wrap. Stopping is also deferred to the period wrap, so a status bit stays high until the pin has returned to its idle level. A sticky per-channel flag records each new period start, and reading it clears it.

Top module: `qpwm_top`

## Requirements
- R1: After reset every channel is stopped, every readable register returns zero and every pin is low.
- R2: Channel c occupies the block at 0x200 + c*0x20. The mode register at +0x00 holds the prescaler in bits [3:0], polarity in bit 9 and the staging target in bit 10, and it reads back with all other bits zero. The threshold is at +0x04, the period at +0x08 and the staging register at +0x10, each 16 bits wide. Reads of any other address, including the write-only 0x04 and 0x08, return zero.
- R3: Writing a one to bit c at 0x04 starts channel c. Bit c of the status register at 0x0C reads one while channel c runs.
- R4: While a channel runs, its counter steps from 0 to period-1 once per prescaled tick and then wraps. The pin is active when the count is at or above the threshold, so a period holds (period - threshold) active ticks. A threshold at or above the period gives no active ticks, and a period of 0 keeps the pin inactive.
- R5: A prescaler value n stretches each tick to 2^n clock cycles. Values above 10 act as 10.
- R6: With polarity 0 the pin is high when active. With polarity 1 it is inverted. A stopped channel holds its pin at the polarity bit.
- R7: A write to the staging register takes effect at the next period wrap. It goes into the threshold when bit 10 of the mode register is 0 and into the period when bit 10 is 1. Until that wrap, the target register reads back its old value.
- R8: Writing a one to bit c at 0x08 stops channel c at the end of its current period. Status bit c stays one until then. Afterwards the counter is back at zero and the pin is idle.
- R9: While a channel runs, writes to its mode, threshold and period registers are ignored.
- R10: The register at 0x1C has bit c set whenever channel c wraps into a new period while it stays running. A read returns all bits and clears them. A bit being set in the same cycle as the read is returned and stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Single-cycle write strobe |
| rd_en | input | 1 | Single-cycle read strobe (clears the period-start flags when reading 0x1C) |
| addr | input | 12 | Byte address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid in the cycle of rd_en, zero otherwise |
| pwm_out | output | 4 | One pulse-width modulated pin per channel |

## Verification
The bench builds the block with its default parameters, four channels and 16-bit counts, and programs only short periods. This makes it possible to sweep every combination of period 1 to 5, threshold 0 to 6, prescaler 0 to 2 and both polarities, rotating across all channels. For each combination the active cycles over one period are counted and compared against (period - threshold) * 2^prescaler. A prescaler of 15 checks the clamp to 1024-cycle ticks. Directed sequences, timed cycle by cycle from the enabling write, cover the staged update, the deferred stop, the ignored writes and the read-clear race on the flag register.

// File: rtl/qpwm_pkg.sv
// Shared constants and types for the four-channel pulse-width modulator.
// Assumes a 12-bit byte address space; offsets below fix the register map.
package qpwm_pkg;

    // Global register offsets
    localparam logic [11:0] OFS_ENABLE  = 12'h004;
    localparam logic [11:0] OFS_DISABLE = 12'h008;
    localparam logic [11:0] OFS_STATUS  = 12'h00C;
    localparam logic [11:0] OFS_FLAGS   = 12'h01C;

    // Channel block placement
    localparam logic [11:0] CH_BASE     = 12'h200;
    localparam int          CH_SHIFT    = 5;         // 0x20 bytes per channel

    // Offsets inside a channel block
    localparam logic [4:0]  CH_MODE     = 5'h00;
    localparam logic [4:0]  CH_THRESH   = 5'h04;
    localparam logic [4:0]  CH_PERIOD   = 5'h08;
    localparam logic [4:0]  CH_STAGE    = 5'h10;

    // Mode register bit positions
    localparam int          PRE_W       = 4;
    localparam int          POL_BIT     = 9;
    localparam int          TGT_BIT     = 10;
    localparam int          MAX_PRE     = 10;

    // Stored mode fields of one channel
    typedef struct packed {
        logic              tgt_period;   // staging register targets the period
        logic              pol;          // output inversion
        logic [PRE_W-1:0]  pre;          // prescaler exponent
    } mode_t;

endpackage

// File: rtl/qpwm_tick_gen.sv
// Prescaler for one channel: emits a one-cycle tick every 2^n clocks,
// n being the prescaler field clamped to MAX_PRE. The divider is held at
// zero while the channel is stopped so the first tick after a start
// arrives exactly 2^n cycles later.
module qpwm_tick_gen #(
    parameter int PRE_W   = 4,
    parameter int MAX_PRE = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [PRE_W-1:0] pre,
    output logic             tick
);
    localparam int DIV_W = (MAX_PRE > 0) ? MAX_PRE : 1;

    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] mask;
    logic [PRE_W-1:0] eff;
    logic [DIV_W:0]   full;

    // Clamp the exponent and build the low-bit mask of the divider
    always_comb begin
        eff  = (pre > PRE_W'(MAX_PRE)) ? PRE_W'(MAX_PRE) : pre;
        full = ((DIV_W+1)'(1) << eff) - (DIV_W+1)'(1);
        mask = full[DIV_W-1:0];
        tick = run && ((div_q & mask) == mask);
    end

    // Free-running divider while the channel runs
    always_ff @(posedge clk) begin
        if (!rst_n || !run) div_q <= '0;
        else                div_q <= div_q + DIV_W'(1);
    end

endmodule

// File: rtl/qpwm_channel.sv
// One modulator channel: setup registers, staging register, period counter,
// deferred stop and pin generation. Assumes the register interface decodes
// addresses and hands over single-cycle write strobes and start/stop bits.
module qpwm_channel
    import qpwm_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_mode,
    input  logic             wr_thresh,
    input  logic             wr_period,
    input  logic             wr_stage,
    input  mode_t            mode_in,
    input  logic [CNT_W-1:0] val_in,
    input  logic             start_bit,
    input  logic             stop_bit,
    output mode_t            mode_o,
    output logic [CNT_W-1:0] thresh_o,
    output logic [CNT_W-1:0] period_o,
    output logic [CNT_W-1:0] stage_o,
    output logic             running_o,
    output logic             new_period_o,
    output logic             pin_o
);
    mode_t            mode_q;
    logic [CNT_W-1:0] thr_q, per_q, stg_q, cnt_q;
    logic             stg_pend_q, run_q, stop_q;
    logic             tick, last, wrap, stop_now, active;

    qpwm_tick_gen #(.PRE_W(PRE_W), .MAX_PRE(MAX_PRE)) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (run_q),
        .pre  (mode_q.pre),
        .tick (tick)
    );

    // Period-end detection and stop resolution
    always_comb begin
        last     = (per_q == '0) || (cnt_q == per_q - CNT_W'(1));
        wrap     = run_q && tick && last;
        stop_now = stop_q || stop_bit;
        active   = run_q && (per_q != '0) && (cnt_q >= thr_q);
    end

    // Run state: start from idle, stop only at a period wrap
    always_ff @(posedge clk) begin
        if (!rst_n)                          run_q <= 1'b0;
        else if (wrap && stop_now)           run_q <= 1'b0;
        else if (!run_q && start_bit && !stop_bit) run_q <= 1'b1;
    end

    // Pending stop request, held until the wrap that honours it
    always_ff @(posedge clk) begin
        if (!rst_n || !run_q || wrap) stop_q <= 1'b0;
        else if (stop_bit)            stop_q <= 1'b1;
    end

    // Period counter stepping on prescaled ticks
    always_ff @(posedge clk) begin
        if (!rst_n || !run_q) cnt_q <= '0;
        else if (tick)        cnt_q <= last ? '0 : cnt_q + CNT_W'(1);
    end

    // Mode register, writable only while stopped
    always_ff @(posedge clk) begin
        if (!rst_n)                  mode_q <= '0;
        else if (wr_mode && !run_q)  mode_q <= mode_in;
    end

    // Threshold register: direct write when stopped, staged load at a wrap
    always_ff @(posedge clk) begin
        if (!rst_n)                                       thr_q <= '0;
        else if (!run_q && wr_thresh)                     thr_q <= val_in;
        else if (wrap && stg_pend_q && !mode_q.tgt_period) thr_q <= stg_q;
    end

    // Period register: direct write when stopped, staged load at a wrap
    always_ff @(posedge clk) begin
        if (!rst_n)                                      per_q <= '0;
        else if (!run_q && wr_period)                    per_q <= val_in;
        else if (wrap && stg_pend_q && mode_q.tgt_period) per_q <= stg_q;
    end

    // Staging register and its pending flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg_q      <= '0;
            stg_pend_q <= 1'b0;
        end else if (wr_stage) begin
            stg_q      <= val_in;
            stg_pend_q <= 1'b1;
        end else if (wrap) begin
            stg_pend_q <= 1'b0;
        end
    end

    assign mode_o       = mode_q;
    assign thresh_o     = thr_q;
    assign period_o     = per_q;
    assign stage_o      = stg_q;
    assign running_o    = run_q;
    assign new_period_o = wrap && !stop_now;
    assign pin_o        = active ^ mode_q.pol;

    // R4
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && per_q != '0) |-> (cnt_q < per_q));

    // R8
    stop_at_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(run_q) |-> $past(tick && last));

    // R9
    mode_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && $past(run_q)) |-> $stable(mode_q));

    // R7
    thresh_at_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && $past(run_q) && !$past(wrap)) |-> $stable(thr_q));

    // R3
    start_needs_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run_q) |-> $past(start_bit));

endmodule

// File: rtl/qpwm_regif.sv
// Register interface: decodes the byte address, produces per-channel write
// strobes and start/stop bits, keeps the sticky period-start flags and
// muxes read data. Assumes single-cycle strobes; read data is combinational.
module qpwm_regif
    import qpwm_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int CNT_W  = 16,
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  mode_t             mode_i   [NUM_CH],
    input  logic [CNT_W-1:0]  thresh_i [NUM_CH],
    input  logic [CNT_W-1:0]  period_i [NUM_CH],
    input  logic [CNT_W-1:0]  stage_i  [NUM_CH],
    input  logic [NUM_CH-1:0] running_i,
    input  logic [NUM_CH-1:0] new_period_i,
    output logic [NUM_CH-1:0] wr_mode_o,
    output logic [NUM_CH-1:0] wr_thresh_o,
    output logic [NUM_CH-1:0] wr_period_o,
    output logic [NUM_CH-1:0] wr_stage_o,
    output mode_t             mode_o,
    output logic [CNT_W-1:0]  val_o,
    output logic [NUM_CH-1:0] start_o,
    output logic [NUM_CH-1:0] stop_o
);
    localparam int                IDX_W  = ADDR_W - CH_SHIFT;
    localparam logic [ADDR_W-1:0] CH_END = ADDR_W'(CH_BASE) + ADDR_W'(NUM_CH << CH_SHIFT);

    logic              in_ch;
    logic [ADDR_W-1:0] rel;
    logic [IDX_W-1:0]  ch_idx;
    logic [4:0]        ofs;
    logic              rd_flags;
    logic [NUM_CH-1:0] flags_q;

    // Address split into channel index and offset inside the block
    always_comb begin
        in_ch  = (addr >= ADDR_W'(CH_BASE)) && (addr < CH_END);
        rel    = addr - ADDR_W'(CH_BASE);
        ch_idx = rel[ADDR_W-1:CH_SHIFT];
        ofs    = rel[4:0];
    end

    // Write data fields handed to every channel
    assign mode_o = '{tgt_period: wdata[TGT_BIT], pol: wdata[POL_BIT], pre: wdata[PRE_W-1:0]};
    assign val_o  = wdata[CNT_W-1:0];

    // Global start and stop bits
    assign start_o = (wr_en && addr == ADDR_W'(OFS_ENABLE))  ? wdata[NUM_CH-1:0] : '0;
    assign stop_o  = (wr_en && addr == ADDR_W'(OFS_DISABLE)) ? wdata[NUM_CH-1:0] : '0;

    // Per-channel write strobes
    for (genvar c = 0; c < NUM_CH; c++) begin : g_strobe
        logic hit;
        assign hit            = wr_en && in_ch && (ch_idx == IDX_W'(c));
        assign wr_mode_o[c]   = hit && (ofs == CH_MODE);
        assign wr_thresh_o[c] = hit && (ofs == CH_THRESH);
        assign wr_period_o[c] = hit && (ofs == CH_PERIOD);
        assign wr_stage_o[c]  = hit && (ofs == CH_STAGE);
    end

    assign rd_flags = rd_en && (addr == ADDR_W'(OFS_FLAGS));

    // Sticky period-start flags, cleared by a read except for bits set now
    always_ff @(posedge clk) begin
        if (!rst_n)        flags_q <= '0;
        else if (rd_flags) flags_q <= new_period_i;
        else               flags_q <= flags_q | new_period_i;
    end

    // Read data multiplexer; unmapped locations read as zero
    always_comb begin
        rdata = '0;
        if (rd_en) begin
            if (addr == ADDR_W'(OFS_STATUS)) begin
                rdata = DATA_W'(running_i);
            end else if (rd_flags) begin
                rdata = DATA_W'(flags_q | new_period_i);
            end else if (in_ch) begin
                for (int c = 0; c < NUM_CH; c++) begin
                    if (ch_idx == IDX_W'(c)) begin
                        case (ofs)
                            CH_MODE: begin
                                rdata[PRE_W-1:0] = mode_i[c].pre;
                                rdata[POL_BIT]   = mode_i[c].pol;
                                rdata[TGT_BIT]   = mode_i[c].tgt_period;
                            end
                            CH_THRESH: rdata = DATA_W'(thresh_i[c]);
                            CH_PERIOD: rdata = DATA_W'(period_i[c]);
                            CH_STAGE:  rdata = DATA_W'(stage_i[c]);
                            default:   rdata = '0;
                        endcase
                    end
                end
            end
        end
    end

    // R10
    flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rd_flags) |-> (flags_q == $past(new_period_i)));

endmodule

// File: rtl/qpwm_top.sv
// Four-channel pulse-width modulator with boundary-staged updates.
// Instantiates the register interface and one channel per output pin.
// Assumes one clock domain and synchronous active-low reset.
module qpwm_top
    import qpwm_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [11:0]       addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    output logic [NUM_CH-1:0] pwm_out
);
    mode_t             mode_w   [NUM_CH];
    logic [CNT_W-1:0]  thresh_w [NUM_CH];
    logic [CNT_W-1:0]  period_w [NUM_CH];
    logic [CNT_W-1:0]  stage_w  [NUM_CH];
    logic [NUM_CH-1:0] running_w, new_period_w;
    logic [NUM_CH-1:0] wr_mode_w, wr_thresh_w, wr_period_w, wr_stage_w;
    logic [NUM_CH-1:0] start_w, stop_w;
    mode_t             mode_in_w;
    logic [CNT_W-1:0]  val_w;

    qpwm_regif #(.NUM_CH(NUM_CH), .CNT_W(CNT_W), .ADDR_W(12), .DATA_W(32)) u_regif (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .rd_en       (rd_en),
        .addr        (addr),
        .wdata       (wdata),
        .rdata       (rdata),
        .mode_i      (mode_w),
        .thresh_i    (thresh_w),
        .period_i    (period_w),
        .stage_i     (stage_w),
        .running_i   (running_w),
        .new_period_i(new_period_w),
        .wr_mode_o   (wr_mode_w),
        .wr_thresh_o (wr_thresh_w),
        .wr_period_o (wr_period_w),
        .wr_stage_o  (wr_stage_w),
        .mode_o      (mode_in_w),
        .val_o       (val_w),
        .start_o     (start_w),
        .stop_o      (stop_w)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        qpwm_channel #(.CNT_W(CNT_W)) u_ch (
            .clk         (clk),
            .rst_n       (rst_n),
            .wr_mode     (wr_mode_w[c]),
            .wr_thresh   (wr_thresh_w[c]),
            .wr_period   (wr_period_w[c]),
            .wr_stage    (wr_stage_w[c]),
            .mode_in     (mode_in_w),
            .val_in      (val_w),
            .start_bit   (start_w[c]),
            .stop_bit    (stop_w[c]),
            .mode_o      (mode_w[c]),
            .thresh_o    (thresh_w[c]),
            .period_o    (period_w[c]),
            .stage_o     (stage_w[c]),
            .running_o   (running_w[c]),
            .new_period_o(new_period_w[c]),
            .pin_o       (pwm_out[c])
        );
    end

endmodule

// File: tb/qpwm_top_tb.sv
module qpwm_top_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [11:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [3:0]  pwm_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    localparam logic [11:0] A_EN = 12'h004, A_DIS = 12'h008, A_ST = 12'h00C, A_FL = 12'h01C;

    qpwm_top u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .pwm_out(pwm_out)
    );

    always #5 clk = ~clk;

    function automatic logic [11:0] cb(input int ch, input int ofs);
        return 12'(12'h200 + ch * 32 + ofs);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // All tasks start and end at a falling edge
    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0; addr = '0; wdata = '0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        rd_en = 1'b1; addr = a;
        #1 d = rdata;
        @(negedge clk);
        rd_en = 1'b0; addr = '0;
    endtask

    task automatic count_active(input int ch, input int n, input logic pol, output int act);
        act = 0;
        for (int i = 0; i < n; i++) begin
            if (pwm_out[ch] !== pol) act++;
            @(negedge clk);
        end
    endtask

    task automatic stop_ch(input int ch);
        logic [31:0] v;
        int guard;
        wr(A_DIS, 32'(1 << ch));
        guard = 0;
        rd(A_ST, v);
        while (v[ch] && guard < 5000) begin
            rd(A_ST, v);
            guard++;
        end
        if (guard >= 5000) check("R8 stop timeout", v, 32'h0);
    endtask

    task automatic setup(input int ch, input logic [31:0] mode, input int thr, input int per);
        wr(cb(ch, 0), mode);
        wr(cb(ch, 4), 32'(thr));
        wr(cb(ch, 8), 32'(per));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        int act, idx, exp_act;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        check("R1 pins", 32'(pwm_out), 32'h0);
        for (int c = 0; c < 4; c++) begin
            for (int o = 0; o < 5; o++) begin
                rd(cb(c, o * 4), v);
                check("R1 channel register", v, 32'h0);
            end
        end
        rd(A_ST, v); check("R1 status", v, 32'h0);
        rd(A_FL, v); check("R1 flags", v, 32'h0);

        // R4 R5 R6: sweep of period, threshold, prescaler and polarity
        idx = 0;
        for (int p = 1; p <= 5; p++) begin
            for (int d = 0; d <= 6; d++) begin
                for (int pr = 0; pr <= 2; pr++) begin
                    for (int pl = 0; pl <= 1; pl++) begin
                        int ch;
                        ch = idx % 4;
                        idx++;
                        setup(ch, 32'(pr) | (32'(pl) << 9), d, p);
                        wr(A_EN, 32'(1 << ch));
                        count_active(ch, p << pr, pl[0], act);
                        exp_act = (d >= p) ? 0 : ((p - d) << pr);
                        check("R4 R5 active cycles per period", 32'(act), 32'(exp_act));
                        stop_ch(ch);
                        check("R6 idle pin level", 32'(pwm_out[ch]), 32'(pl));
                    end
                end
            end
        end

        // R5: prescaler above 10 clamps to 1024-cycle ticks
        setup(1, 32'hF, 1, 2);
        wr(A_EN, 32'h2);
        count_active(1, 2048, 1'b0, act);
        check("R5 clamped prescaler", 32'(act), 32'd1024);
        stop_ch(1);

        // R7: staged threshold
        setup(0, 32'h0, 2, 10);
        wr(A_EN, 32'h1);
        wr(cb(0, 16), 32'd7);
        rd(cb(0, 4), v); check("R7 threshold held before wrap", v, 32'd2);
        repeat (8) @(negedge clk);
        count_active(0, 10, 1'b0, act);
        check("R7 staged threshold waveform", 32'(act), 32'd3);
        rd(cb(0, 4), v); check("R7 threshold after wrap", v, 32'd7);
        stop_ch(0);

        // R7: staged period (mode bit 10 set)
        setup(0, 32'h400, 2, 10);
        wr(A_EN, 32'h1);
        wr(cb(0, 16), 32'd4);
        rd(cb(0, 8), v); check("R7 period held before wrap", v, 32'd10);
        repeat (8) @(negedge clk);
        count_active(0, 8, 1'b0, act);
        check("R7 staged period waveform", 32'(act), 32'd4);
        rd(cb(0, 8), v); check("R7 period after wrap", v, 32'd4);
        stop_ch(0);

        // R8 R3: deferred stop
        setup(3, 32'h0, 0, 8);
        wr(A_EN, 32'h8);
        wr(A_DIS, 32'h8);
        rd(A_ST, v); check("R8 status after stop request", v, 32'h8);
        repeat (4) @(negedge clk);
        rd(A_ST, v); check("R3 R8 status late in period", v, 32'h8);
        check("R8 pin active in last cycle", 32'(pwm_out[3]), 32'h1);
        @(negedge clk);
        check("R8 pin idle after wrap", 32'(pwm_out[3]), 32'h0);
        rd(A_ST, v); check("R8 status cleared", v, 32'h0);

        // R9: setup writes ignored while running
        setup(1, 32'h0, 3, 6);
        wr(A_EN, 32'h2);
        setup(1, 32'h203, 1, 2);
        rd(cb(1, 0), v); check("R9 mode unchanged", v, 32'h0);
        rd(cb(1, 4), v); check("R9 threshold unchanged", v, 32'd3);
        rd(cb(1, 8), v); check("R9 period unchanged", v, 32'd6);
        stop_ch(1);

        // R10 R3: period-start flags and the read-clear race
        rd(A_FL, v);
        setup(0, 32'h0, 5, 20);
        wr(A_EN, 32'h1);
        repeat (19) @(negedge clk);
        rd(A_FL, v); check("R10 flag seen in wrap cycle", v, 32'h1);
        rd(A_FL, v); check("R10 flag kept after race", v, 32'h1);
        rd(A_FL, v); check("R10 flag cleared by read", v, 32'h0);
        rd(A_ST, v); check("R3 status of running channel", v, 32'h1);
        stop_ch(0);

        // R2: field layout and unmapped addresses
        wr(cb(2, 0), 32'hFFFF_FFFF);
        rd(cb(2, 0), v); check("R2 mode fields", v, 32'h0000_060F);
        wr(cb(2, 4), 32'h1234_5678);
        rd(cb(2, 4), v); check("R2 threshold width", v, 32'h0000_5678);
        wr(cb(2, 8), 32'h0000_ABCD);
        rd(cb(2, 8), v); check("R2 period", v, 32'h0000_ABCD);
        wr(cb(2, 16), 32'h0000_1111);
        rd(cb(2, 16), v); check("R2 staging", v, 32'h0000_1111);
        rd(12'h010, v); check("R2 unmapped global", v, 32'h0);
        rd(12'h280, v); check("R2 past last channel", v, 32'h0);
        rd(cb(2, 12), v); check("R2 unmapped channel offset", v, 32'h0);
        rd(A_EN, v); check("R2 enable reads zero", v, 32'h0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule